// File: doc/BRIEF.md
# Inter-VM Doorbell Register Block

This block is the small register window that a guest sees for a shared-memory inter-VM device. A simple 32-bit request bus reaches it, with one request per cycle and read data returned one cycle later. It holds an interrupt enable word, an interrupt flag word, a read-only peer identity word and a write-only doorbell word. A write to the doorbell is turned into a one-cycle pulse that carries a target peer and a vector number toward the transport. A peer event coming in from that transport raises an interrupt toward the local guest.

The parameter `REV` selects which behaviour the block presents. With revision 0 and message-signalled interrupts off, the legacy path is active: a peer event latches flag bit 0, and a level interrupt follows the AND of flag and enable. A read of the flag word clears it. With revision 1, or with message-signalled interrupts on, a peer event instead produces a one-cycle pulse on the line of the selected vector. With revision 1, bit 0 of the enable and flag words is reserved. The identity word returns all ones until an external server supplies the peer ID. On a device built without interrupt support, the identity word always returns zero.

Top module: `dbell_regblk`

## Requirements
- R1: After reset the enable and flag words read 0, `intx_o`, `db_fire`, `bus_rvalid` and every `vec_pulse` line are low, and on a device with interrupt support the identity word (byte offset 8) reads 32'hFFFF_FFFF.
- R2: With `REV`=0, bit 0 of the enable word (byte offset 0) is read/write, and bits 31:1 read 0 whatever was written.
- R3: In legacy interrupt mode (`REV`=0, `MSG_IRQ`=0, interrupts supported), `peer_evt` sets flag bit 0 (byte offset 4). A read of the flag word returns its value before the read and leaves it 0.
- R4: When `peer_evt` arrives in the same cycle as a read of the flag word, the read returns the earlier value and the flag bit remains 1 afterwards.
- R5: `intx_o` is high exactly when flag bit 0 and enable bit 0 are both 1 and the block is in legacy interrupt mode. It changes in the cycle after the edge that updates either bit, and it is always low in every other mode.
- R6: With `REV`=1, the enable and flag words always read 0, writes to them have no effect, and `peer_evt` sets nothing.
- R7: In vector mode (interrupts supported, and not legacy interrupt mode), `peer_evt` with vector v makes `vec_pulse` equal to 1<<v for exactly the one cycle after the event edge, and to 0 in every other cycle.
- R8: Once `id_set` has been high at an edge, the identity word reads `id_val` zero-extended to 32 bits. Writes to offset 8 are ignored. On a device without interrupt support (`IRQ_CFG`=0) the identity word reads 0, and `id_set` and `peer_evt` have no effect.
- R9: A write to the doorbell word (byte offset 12) makes `db_fire` high for the one following cycle, with `db_peer` = wdata[31:16] and `db_vec` = wdata[15:0].
- R10: Reads of the doorbell word, of offsets 16 and above, and of any address with bits 1:0 non-zero return 0. Writes to such unmapped or misaligned addresses change no register.
- R11: A read request yields `bus_rvalid` high with the data one cycle later. When no read result is presented, `bus_rvalid` is low and `bus_rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Access request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address inside the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read result present |
| peer_evt | input | 1 | Interrupt request arriving from a peer |
| peer_vec | input | VEC_W | Vector selected by that request |
| id_set | input | 1 | Server delivers the peer ID |
| id_val | input | 16 | Peer ID delivered |
| intx_o | output | 1 | Legacy level interrupt |
| vec_pulse | output | NUM_VEC | One-cycle per-vector message interrupt |
| db_fire | output | 1 | Doorbell write pulse |
| db_peer | output | 16 | Target peer of the doorbell |
| db_vec | output | 16 | Vector number of the doorbell |

## Verification
The in-RTL properties watch, on every cycle, that a legacy peer event always leaves the flag set and that a flag read with no coincident event leaves it clear. They also check that vector pulses and doorbell pulses appear only after a matching cause, and that read data is only presented after a read request. The bench's scenarios are needed for the rest. These are the values read back in each revision, masking of the level interrupt, ignored writes to reserved bits and to unmapped or misaligned addresses, the identity word before and after the server assigns it, and the doorbell field split. Three instances built with different parameters share one stimulus so these cases can be compared.

// File: rtl/dbell_pkg.sv
package dbell_pkg;
   localparam int REG_W = 32;
   localparam int ID_W  = 16;

   typedef enum logic [1:0] {
      SLOT_EN   = 2'd0,
      SLOT_FLAG = 2'd1,
      SLOT_IDN  = 2'd2,
      SLOT_RING = 2'd3
   } slot_e;

   typedef struct packed {
      logic rd_any;
      logic rd_en;
      logic rd_flag;
      logic rd_idn;
      logic wr_en;
      logic wr_flag;
      logic wr_ring;
   } acc_t;
endpackage

// File: rtl/dbell_decode.sv
module dbell_decode
   import dbell_pkg::*;
#(
   parameter int ADDR_W = 8
) (
   input  logic              req,
   input  logic              wr,
   input  logic [ADDR_W-1:0] addr,
   output acc_t              acc
);
   logic  hit;
   slot_e slot;

   always_comb begin
      hit  = (addr[ADDR_W-1:4] == '0) && (addr[1:0] == 2'b00);
      slot = slot_e'(addr[3:2]);
      acc  = '0;
      acc.rd_any  = req && !wr;
      acc.rd_en   = req && !wr && hit && (slot == SLOT_EN);
      acc.rd_flag = req && !wr && hit && (slot == SLOT_FLAG);
      acc.rd_idn  = req && !wr && hit && (slot == SLOT_IDN);
      acc.wr_en   = req && wr  && hit && (slot == SLOT_EN);
      acc.wr_flag = req && wr  && hit && (slot == SLOT_FLAG);
      acc.wr_ring = req && wr  && hit && (slot == SLOT_RING);
   end
endmodule

// File: rtl/dbell_irq_core.sv
module dbell_irq_core
   import dbell_pkg::*;
#(
   parameter int REV     = 0,
   parameter bit MSG_IRQ = 1'b0,
   parameter bit IRQ_CFG = 1'b1,
   parameter int NUM_VEC = 4,
   localparam int VEC_W  = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  acc_t               acc,
   input  logic               wbit0,
   input  logic               peer_evt,
   input  logic [VEC_W-1:0]   peer_vec,
   output logic               en_bit,
   output logic               flag_bit,
   output logic               intx_o,
   output logic [NUM_VEC-1:0] vec_pulse
);
   localparam bit LEGACY_IRQ = (REV == 0) && !MSG_IRQ && IRQ_CFG;
   localparam bit VECTOR_IRQ = IRQ_CFG && !LEGACY_IRQ;

   generate
      if (REV == 0) begin : g_bits
         logic en_q, flag_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               en_q   <= 1'b0;
               flag_q <= 1'b0;
            end else begin
               if (acc.wr_en) en_q <= wbit0;
               if (LEGACY_IRQ && peer_evt) flag_q <= 1'b1;
               else if (acc.wr_flag)       flag_q <= wbit0;
               else if (acc.rd_flag)       flag_q <= 1'b0;
            end
         end
         assign en_bit   = en_q;
         assign flag_bit = flag_q;

         // R4
         legacy_evt_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (LEGACY_IRQ && peer_evt) |=> flag_q);
         // R3
         flag_read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (acc.rd_flag && !peer_evt) |=> !flag_q);
      end else begin : g_reserved
         assign en_bit   = 1'b0;
         assign flag_bit = 1'b0;
      end

      if (LEGACY_IRQ) begin : g_intx
         assign intx_o = en_bit & flag_bit;
      end else begin : g_no_intx
         assign intx_o = 1'b0;
      end

      if (VECTOR_IRQ) begin : g_vec
         logic [NUM_VEC-1:0] pulse_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        pulse_q <= '0;
            else if (peer_evt) pulse_q <= NUM_VEC'(1) << peer_vec;
            else               pulse_q <= '0;
         end
         assign vec_pulse = pulse_q;

         // R7
         vec_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !peer_evt |=> (vec_pulse == '0));
      end else begin : g_no_vec
         assign vec_pulse = '0;
      end
   endgenerate
endmodule

// File: rtl/dbell_ident.sv
module dbell_ident
   import dbell_pkg::*;
#(
   parameter bit IRQ_CFG = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             id_set,
   input  logic [ID_W-1:0]  id_val,
   output logic [REG_W-1:0] id_word
);
   generate
      if (IRQ_CFG) begin : g_assigned
         logic            known_q;
         logic [ID_W-1:0] id_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               known_q <= 1'b0;
               id_q    <= '0;
            end else if (id_set) begin
               known_q <= 1'b1;
               id_q    <= id_val;
            end
         end
         assign id_word = known_q ? REG_W'(id_q) : '1;

         // R8
         id_known_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(known_q) |-> $past(id_set));
      end else begin : g_none
         assign id_word = '0;
      end
   endgenerate
endmodule

// File: rtl/dbell_regblk.sv
module dbell_regblk
   import dbell_pkg::*;
#(
   parameter int REV     = 0,
   parameter bit MSG_IRQ = 1'b0,
   parameter bit IRQ_CFG = 1'b1,
   parameter int NUM_VEC = 4,
   parameter int ADDR_W  = 8,
   localparam int VEC_W  = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               bus_req,
   input  logic               bus_wr,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic [REG_W-1:0]   bus_wdata,
   output logic [REG_W-1:0]   bus_rdata,
   output logic               bus_rvalid,
   input  logic               peer_evt,
   input  logic [VEC_W-1:0]   peer_vec,
   input  logic               id_set,
   input  logic [ID_W-1:0]    id_val,
   output logic               intx_o,
   output logic [NUM_VEC-1:0] vec_pulse,
   output logic               db_fire,
   output logic [ID_W-1:0]    db_peer,
   output logic [ID_W-1:0]    db_vec
);
   generate
      if (REV < 0 || REV > 1) begin : g_bad_rev
         $error("REV must be 0 or 1");
      end
      if (ADDR_W < 4) begin : g_bad_addr
         $error("ADDR_W must cover four word slots");
      end
      if (NUM_VEC < 2 || NUM_VEC != (1 << VEC_W)) begin : g_bad_vec
         $error("NUM_VEC must be a power of two, at least 2");
      end
   endgenerate

   acc_t             acc;
   logic             en_bit, flag_bit;
   logic [REG_W-1:0] id_word;
   logic [REG_W-1:0] rd_next;

   dbell_decode #(.ADDR_W(ADDR_W)) u_dec (
      .req  (bus_req),
      .wr   (bus_wr),
      .addr (bus_addr),
      .acc  (acc)
   );

   dbell_irq_core #(
      .REV(REV), .MSG_IRQ(MSG_IRQ), .IRQ_CFG(IRQ_CFG), .NUM_VEC(NUM_VEC)
   ) u_irq (
      .clk       (clk),
      .rst_n     (rst_n),
      .acc       (acc),
      .wbit0     (bus_wdata[0]),
      .peer_evt  (peer_evt),
      .peer_vec  (peer_vec),
      .en_bit    (en_bit),
      .flag_bit  (flag_bit),
      .intx_o    (intx_o),
      .vec_pulse (vec_pulse)
   );

   dbell_ident #(.IRQ_CFG(IRQ_CFG)) u_id (
      .clk     (clk),
      .rst_n   (rst_n),
      .id_set  (id_set),
      .id_val  (id_val),
      .id_word (id_word)
   );

   always_comb begin
      rd_next = '0;
      if (acc.rd_en)   rd_next = REG_W'(en_bit);
      if (acc.rd_flag) rd_next = REG_W'(flag_bit);
      if (acc.rd_idn)  rd_next = id_word;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bus_rvalid <= 1'b0;
         bus_rdata  <= '0;
         db_fire    <= 1'b0;
         db_peer    <= '0;
         db_vec     <= '0;
      end else begin
         bus_rvalid <= acc.rd_any;
         bus_rdata  <= acc.rd_any ? rd_next : '0;
         db_fire    <= acc.wr_ring;
         if (acc.wr_ring) begin
            db_peer <= bus_wdata[31:16];
            db_vec  <= bus_wdata[15:0];
         end
      end
   end

   // R11
   rvalid_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rvalid |-> $past(bus_req && !bus_wr));
   // R9
   db_fire_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      db_fire |-> $past(bus_req && bus_wr));
   // R5
   intx_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      intx_o |-> (en_bit && flag_bit));
endmodule

// File: tb/sim_dbell_regblk.sv
module sim_dbell_regblk;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_req = 1'b0, bus_wr = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic        peer_evt = 1'b0;
   logic [1:0]  peer_vec = '0;
   logic        id_set = 1'b0;
   logic [15:0] id_val = '0;

   logic [31:0] rd_w [3];
   logic        rv_w [3];
   logic        ix_w [3];
   logic [3:0]  vp_w [3];
   logic        df_w [3];
   logic [15:0] dp_w [3];
   logic [15:0] dv_w [3];

   int checks = 0, errors = 0;
   bit started = 1'b0;

   always #4 clk = ~clk;

   dbell_regblk #(.REV(0), .MSG_IRQ(1'b0), .IRQ_CFG(1'b1)) u0 (
      .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rd_w[0]),
      .bus_rvalid(rv_w[0]), .peer_evt(peer_evt), .peer_vec(peer_vec),
      .id_set(id_set), .id_val(id_val), .intx_o(ix_w[0]), .vec_pulse(vp_w[0]),
      .db_fire(df_w[0]), .db_peer(dp_w[0]), .db_vec(dv_w[0]));
   dbell_regblk #(.REV(1), .MSG_IRQ(1'b0), .IRQ_CFG(1'b1)) u1 (
      .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rd_w[1]),
      .bus_rvalid(rv_w[1]), .peer_evt(peer_evt), .peer_vec(peer_vec),
      .id_set(id_set), .id_val(id_val), .intx_o(ix_w[1]), .vec_pulse(vp_w[1]),
      .db_fire(df_w[1]), .db_peer(dp_w[1]), .db_vec(dv_w[1]));
   dbell_regblk #(.REV(0), .MSG_IRQ(1'b0), .IRQ_CFG(1'b0)) u2 (
      .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rd_w[2]),
      .bus_rvalid(rv_w[2]), .peer_evt(peer_evt), .peer_vec(peer_vec),
      .id_set(id_set), .id_val(id_val), .intx_o(ix_w[2]), .vec_pulse(vp_w[2]),
      .db_fire(df_w[2]), .db_peer(dp_w[2]), .db_vec(dv_w[2]));

   // behavioural reference, one entry per instance
   int          k_rev [3] = '{0, 1, 0};
   bit          k_cfg [3] = '{1'b1, 1'b1, 1'b0};
   bit          m_en [3], m_flag [3], m_known [3];
   logic [15:0] m_id [3];
   logic [31:0] e_rd [3];
   bit          e_rv [3], e_ix [3], e_df [3];
   logic [3:0]  e_vp [3];
   logic [15:0] e_dp [3], e_dv [3];

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   always @(posedge clk) begin
      for (int k = 0; k < 3; k++) begin
         bit legacy, vmode, hit, rdq, wrq;
         logic [1:0] slot;
         legacy = (k_rev[k] == 0) && k_cfg[k];
         vmode  = k_cfg[k] && !legacy;
         if (!rst_n) begin
            m_en[k] = 0; m_flag[k] = 0; m_known[k] = 0; m_id[k] = '0;
            e_rd[k] = '0; e_rv[k] = 0; e_ix[k] = 0; e_df[k] = 0; e_vp[k] = '0;
            e_dp[k] = '0; e_dv[k] = '0;
         end else begin
            hit  = (bus_addr[7:4] == 4'h0) && (bus_addr[1:0] == 2'b00);
            slot = bus_addr[3:2];
            rdq  = bus_req && !bus_wr;
            wrq  = bus_req && bus_wr;
            e_rv[k] = rdq;
            e_rd[k] = '0;
            if (rdq && hit) begin
               case (slot)
                  2'd0: e_rd[k] = {31'b0, m_en[k]};
                  2'd1: e_rd[k] = {31'b0, m_flag[k]};
                  2'd2: e_rd[k] = !k_cfg[k] ? 32'h0 :
                                  (m_known[k] ? {16'h0, m_id[k]} : 32'hFFFF_FFFF);
                  default: e_rd[k] = '0;
               endcase
            end
            if (rdq && hit && slot == 2'd1) m_flag[k] = 0;
            if (wrq && hit && slot == 2'd0 && k_rev[k] == 0) m_en[k] = bus_wdata[0];
            if (wrq && hit && slot == 2'd1 && k_rev[k] == 0) m_flag[k] = bus_wdata[0];
            if (peer_evt && legacy) m_flag[k] = 1;
            e_vp[k] = (peer_evt && vmode) ? (4'b1 << peer_vec) : 4'b0;
            if (id_set && k_cfg[k]) begin m_known[k] = 1; m_id[k] = id_val; end
            e_df[k] = wrq && hit && slot == 2'd3;
            if (e_df[k]) begin e_dp[k] = bus_wdata[31:16]; e_dv[k] = bus_wdata[15:0]; end
            e_ix[k] = legacy && m_en[k] && m_flag[k];
         end
      end
      started = 1'b1;
   end

   always @(negedge clk) begin
      if (started) begin
         for (int k = 0; k < 3; k++) begin
            chk($sformatf("R11 u%0d rvalid", k), {31'b0, rv_w[k]}, {31'b0, e_rv[k]});
            chk($sformatf("R11 u%0d rdata", k), rd_w[k], e_rd[k]);
            chk($sformatf("R5 u%0d intx", k), {31'b0, ix_w[k]}, {31'b0, e_ix[k]});
            chk($sformatf("R7 u%0d vec_pulse", k), {28'b0, vp_w[k]}, {28'b0, e_vp[k]});
            chk($sformatf("R9 u%0d db_fire", k), {31'b0, df_w[k]}, {31'b0, e_df[k]});
            if (e_df[k])
               chk($sformatf("R9 u%0d db fields", k), {dp_w[k], dv_w[k]}, {e_dp[k], e_dv[k]});
         end
      end
   end

   task automatic go(); @(posedge clk); #2; endtask

   task automatic rd(input logic [7:0] a);
      go(); bus_req = 1; bus_wr = 0; bus_addr = a;
      go(); bus_req = 0;
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      go(); bus_req = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
      go(); bus_req = 0; bus_wr = 0;
   endtask

   task automatic evt(input logic [1:0] v);
      go(); peer_evt = 1; peer_vec = v;
      go(); peer_evt = 0;
   endtask

   initial begin
      #200000;
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #2 rst_n = 1;
      go();
      chk("R1 u0 intx", {31'b0, ix_w[0]}, 32'h0);
      rd(8'h08);
      chk("R1 u0 id before server", rd_w[0], 32'hFFFF_FFFF);
      chk("R8 u2 id no irq", rd_w[2], 32'h0);
      rd(8'h04);
      chk("R1 u0 flag reset", rd_w[0], 32'h0);

      wr(8'h00, 32'hFFFF_FFFF);
      rd(8'h00);
      chk("R2 u0 enable bit0 only", rd_w[0], 32'h1);
      chk("R6 u1 enable reserved", rd_w[1], 32'h0);

      evt(2'd2);
      chk("R5 u0 intx raised", {31'b0, ix_w[0]}, 32'h1);
      chk("R7 u1 pulse vector 2", {28'b0, vp_w[1]}, 32'h4);
      go();
      chk("R7 u1 pulse one cycle", {28'b0, vp_w[1]}, 32'h0);
      rd(8'h04);
      chk("R3 u0 flag read old", rd_w[0], 32'h1);
      chk("R6 u1 flag reserved", rd_w[1], 32'h0);
      chk("R5 u0 intx after clear", {31'b0, ix_w[0]}, 32'h0);
      rd(8'h04);
      chk("R3 u0 flag cleared", rd_w[0], 32'h0);

      evt(2'd1);
      go(); bus_req = 1; bus_wr = 0; bus_addr = 8'h04; peer_evt = 1; peer_vec = 2'd3;
      go(); bus_req = 0; peer_evt = 0;
      chk("R4 u0 coincident read old", rd_w[0], 32'h1);
      chk("R7 u1 pulse vector 3", {28'b0, vp_w[1]}, 32'h8);
      rd(8'h04);
      chk("R4 u0 flag kept", rd_w[0], 32'h1);

      wr(8'h00, 32'h0);
      wr(8'h04, 32'h1);
      chk("R5 u0 masked", {31'b0, ix_w[0]}, 32'h0);
      wr(8'h00, 32'h1);
      chk("R5 u0 unmasked", {31'b0, ix_w[0]}, 32'h1);
      wr(8'h04, 32'h1);
      rd(8'h04);
      chk("R6 u1 flag write ignored", rd_w[1], 32'h0);

      go(); id_set = 1; id_val = 16'h1234;
      go(); id_set = 0;
      wr(8'h08, 32'h0000_5555);
      rd(8'h08);
      chk("R8 u0 id assigned", rd_w[0], 32'h0000_1234);
      chk("R8 u1 id assigned", rd_w[1], 32'h0000_1234);
      chk("R8 u2 id stays zero", rd_w[2], 32'h0);

      wr(8'h0C, 32'hABCD_0003);
      go();
      wr(8'h0C, 32'h0007_0001);
      rd(8'h0C);
      chk("R10 u0 doorbell reads zero", rd_w[0], 32'h0);
      wr(8'h40, 32'h0);
      wr(8'h01, 32'h0);
      rd(8'h00);
      chk("R10 u0 unmapped write ignored", rd_w[0], 32'h1);
      rd(8'h41);
      chk("R10 u0 unmapped read", rd_w[0], 32'h0);
      rd(8'h02);
      chk("R10 u0 misaligned read", rd_w[0], 32'h0);
      go();
      chk("R11 u0 idle rvalid", {31'b0, rv_w[0]}, 32'h0);
      repeat (4) go();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule